// File: doc/BRIEF.md
# Receive Signaling Freeze Controller

This block guards the per-channel store of received robbed-bit ABCD signaling. An update strobe carries a channel number and a 4-bit signaling nibble. The strobe is written into the store only while the block is unfrozen. A freeze can be requested by a software control bit. It can also arise automatically from loss of signal, from loss of frame alignment, or from a receive slip. The slip source counts only while the external signaling access mode is selected. All active sources are ORed into one freeze condition. A registered copy of that condition drives a dedicated output pin and a status bit with the same value.

When the freeze condition goes away, writes do not restart at once. The controller waits until it has seen one complete superframe, which runs from one superframe start strobe to the next. Only then are writes enabled again. If a freeze source reappears during that wait, the wait begins again from the start. Reset clears every stored nibble. It also puts the controller into the same waiting state, so after reset the first complete superframe must pass before any write is accepted.

Top module: `sig_freeze_ctrl`

## Requirements
- R1: After reset all stored nibbles read 0, the freeze pin and status bit are 0, and the write enable output is 0.
- R2: The freeze condition is force-freeze OR loss-of-signal OR loss-of-frame OR (slip AND external access mode). The freeze pin shows this condition one clock after it is sampled. The status bit always equals the pin.
- R3: When external access mode is 0, the slip input has no effect. The pin stays 0, and writes in the running state still go through.
- R4: In any cycle where the freeze condition is true, the write enable output is 0, no write takes place, and every stored nibble is held.
- R5: Once the condition is false, the write enable rises in the clock after the second superframe start strobe sampled with the condition false. It stays 0 after only the first such strobe.
- R6: If the condition becomes true during the waiting superframe, two further strobes are needed after it clears.
- R7: While the write enable is 1, an update strobe writes its nibble to its channel (0 to 23). The nibble can be read on the combinational read port one clock later. A channel number of 24 or higher writes nothing and reads 0.
- R8: Superframe strobes that arrive while the condition is true do not count toward the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_freeze_i | input | 1 | Software freeze request |
| los_i | input | 1 | Loss-of-signal alarm level |
| lof_i | input | 1 | Loss-of-frame-alignment alarm level |
| slip_i | input | 1 | Receive slip indication |
| ext_sig_mode_i | input | 1 | External signaling access mode; enables slip freeze |
| sf_start_i | input | 1 | Superframe start strobe |
| upd_valid_i | input | 1 | Signaling update strobe |
| upd_ch_i | input | 5 | Channel of the update |
| upd_data_i | input | 4 | ABCD nibble of the update |
| rd_ch_i | input | 5 | Read channel select |
| rd_data_o | output | 4 | Stored nibble of the selected channel |
| upd_en_o | output | 1 | Writes currently accepted |
| freeze_pin_o | output | 1 | Freeze status pin |
| freeze_stat_o | output | 1 | Freeze status bit |

## Verification
Three latencies apply. The freeze pin and status bit follow a source one clock after it is sampled. The write enable drops in the same cycle as the freeze condition, and rises one clock after the closing superframe strobe. A written nibble can be read one clock after its strobe. The bench drives every input on the falling edge. It samples at the next falling edge after the rising edge that carries the stimulus, so each check falls exactly one register stage later. Checks of the blocked write state and the ignored slip read the stored nibble back through the read port.

// File: rtl/sfz_pkg.sv
package sfz_pkg;
   // Resume sequencing states
   typedef enum logic [1:0] {
      SFZ_HOLD = 2'd0,   // frozen or waiting for the opening strobe
      SFZ_SPAN = 2'd1,   // inside the superframe that must complete
      SFZ_RUN  = 2'd2    // updates allowed
   } sfz_state_e;
endpackage

// File: rtl/sfz_cond.sv
module sfz_cond #(
   parameter bit SLIP_GATE  = 1'b1,
   parameter bit REG_STATUS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_freeze_i,
   input  logic los_i,
   input  logic lof_i,
   input  logic slip_i,
   input  logic ext_sig_mode_i,
   output logic cond_o,
   output logic status_o
);
   logic slip_term;
   logic status_q;

   generate
      if (SLIP_GATE) begin : g_slip_gated
         assign slip_term = slip_i & ext_sig_mode_i;
      end else begin : g_slip_open
         assign slip_term = slip_i;
      end
   endgenerate

   assign cond_o = force_freeze_i | los_i | lof_i | slip_term;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= cond_o;
   end

   generate
      if (REG_STATUS) begin : g_stat_reg
         assign status_o = status_q;
      end else begin : g_stat_comb
         assign status_o = cond_o;
      end
   endgenerate
endmodule

// File: rtl/sfz_resume.sv
module sfz_resume
   import sfz_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic sf_start_i,
   output logic upd_en_o
);
   sfz_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (cond_i) begin
         state_d = SFZ_HOLD;
      end else begin
         unique case (state_q)
            SFZ_HOLD: if (sf_start_i) state_d = SFZ_SPAN;
            SFZ_SPAN: if (sf_start_i) state_d = SFZ_RUN;
            SFZ_RUN:  state_d = SFZ_RUN;
            default:  state_d = SFZ_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SFZ_HOLD;
      else        state_q <= state_d;
   end

   assign upd_en_o = (state_q == SFZ_RUN) & ~cond_i;

   // R4: any freeze source throws the sequencer back to the start
   p_hold_on_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i |=> (state_q == SFZ_HOLD));

   // R5: running state is only entered on a strobe with no freeze active
   p_run_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SFZ_RUN) && ($past(state_q) != SFZ_RUN))
         |-> $past(sf_start_i && !cond_i));
endmodule

// File: rtl/sfz_sigbuf.sv
module sfz_sigbuf #(
   parameter int NUM_CH = 24,
   parameter int SIG_W  = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [CH_W-1:0]  wch_i,
   input  logic [SIG_W-1:0] wdata_i,
   input  logic [CH_W-1:0]  rch_i,
   output logic [SIG_W-1:0] rdata_o
);
   logic [NUM_CH*SIG_W-1:0] mem_flat;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [SIG_W-1:0] nib_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                              nib_q <= '0;
            else if (we_i && (wch_i == CH_W'(ch)))   nib_q <= wdata_i;
         end
         assign mem_flat[ch*SIG_W +: SIG_W] = nib_q;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rch_i == CH_W'(i)) rdata_o = mem_flat[i*SIG_W +: SIG_W];
      end
   end

   // R4: without a write strobe the whole store is held
   p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mem_flat));
endmodule

// File: rtl/sig_freeze_ctrl.sv
module sig_freeze_ctrl #(
   parameter int NUM_CH     = 24,
   parameter int SIG_W      = 4,
   parameter bit SLIP_GATE  = 1'b1,
   parameter bit REG_STATUS = 1'b1,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_freeze_i,
   input  logic             los_i,
   input  logic             lof_i,
   input  logic             slip_i,
   input  logic             ext_sig_mode_i,
   input  logic             sf_start_i,
   input  logic             upd_valid_i,
   input  logic [CH_W-1:0]  upd_ch_i,
   input  logic [SIG_W-1:0] upd_data_i,
   input  logic [CH_W-1:0]  rd_ch_i,
   output logic [SIG_W-1:0] rd_data_o,
   output logic             upd_en_o,
   output logic             freeze_pin_o,
   output logic             freeze_stat_o
);
   initial begin
      assert (NUM_CH >= 1) else $fatal(1, "NUM_CH must be at least 1");
      assert (SIG_W >= 1)  else $fatal(1, "SIG_W must be at least 1");
   end

   logic cond;
   logic status;
   logic en;
   logic ch_ok;
   logic we;

   sfz_cond #(.SLIP_GATE(SLIP_GATE), .REG_STATUS(REG_STATUS)) u_cond (
      .clk            (clk),
      .rst_n          (rst_n),
      .force_freeze_i (force_freeze_i),
      .los_i          (los_i),
      .lof_i          (lof_i),
      .slip_i         (slip_i),
      .ext_sig_mode_i (ext_sig_mode_i),
      .cond_o         (cond),
      .status_o       (status)
   );

   sfz_resume u_resume (
      .clk        (clk),
      .rst_n      (rst_n),
      .cond_i     (cond),
      .sf_start_i (sf_start_i),
      .upd_en_o   (en)
   );

   assign ch_ok = ({1'b0, upd_ch_i} < (CH_W+1)'(NUM_CH));
   assign we    = upd_valid_i & en & ch_ok;

   sfz_sigbuf #(.NUM_CH(NUM_CH), .SIG_W(SIG_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .wch_i   (upd_ch_i),
      .wdata_i (upd_data_i),
      .rch_i   (rd_ch_i),
      .rdata_o (rd_data_o)
   );

   assign upd_en_o      = en;
   assign freeze_pin_o  = status;
   assign freeze_stat_o = status;

   // R4: a manual freeze blocks writes in the same cycle
   p_force_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      force_freeze_i |-> !upd_en_o);

   generate
      if (REG_STATUS) begin : g_pin_chk
         // R2: alarm sources show on the pin one clock later
         p_pin_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (force_freeze_i | los_i | lof_i) |=> freeze_pin_o);
         if (SLIP_GATE) begin : g_slip_chk
            // R3: slip alone without external mode leaves the pin low
            p_slip_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (slip_i & !ext_sig_mode_i & !force_freeze_i & !los_i & !lof_i)
                  |=> !freeze_pin_o);
         end
      end
   endgenerate
endmodule

// File: tb/sig_freeze_ctrl_tb.sv
`timescale 1ns/1ps
module sig_freeze_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       force_freeze, los, lof, slip, ext_mode, sf_start, upd_valid;
   logic [4:0] upd_ch, rd_ch;
   logic [3:0] upd_data, rd_data;
   logic       upd_en, pin, stat;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sig_freeze_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .force_freeze_i(force_freeze), .los_i(los),
      .lof_i(lof), .slip_i(slip), .ext_sig_mode_i(ext_mode), .sf_start_i(sf_start),
      .upd_valid_i(upd_valid), .upd_ch_i(upd_ch), .upd_data_i(upd_data),
      .rd_ch_i(rd_ch), .rd_data_o(rd_data), .upd_en_o(upd_en),
      .freeze_pin_o(pin), .freeze_stat_o(stat)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic sf_pulse();
      sf_start = 1'b1;
      step();
      sf_start = 1'b0;
   endtask

   task automatic go_run();
      step();
      sf_pulse();
      step();
      sf_pulse();
   endtask

   task automatic write_nib(input int ch, input int d);
      upd_valid = 1'b1; upd_ch = 5'(ch); upd_data = 4'(d);
      step();
      upd_valid = 1'b0;
   endtask

   task automatic read_nib(input int ch, output int d);
      rd_ch = 5'(ch);
      #0.1;
      d = int'(rd_data);
   endtask

   task automatic t_reset();
      int d;
      rst_n = 1'b0;
      force_freeze = 0; los = 0; lof = 0; slip = 0; ext_mode = 0;
      sf_start = 0; upd_valid = 0; upd_ch = 0; upd_data = 0; rd_ch = 0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      read_nib(0, d);  chk("R1 nibble ch0", d, 0);
      read_nib(23, d); chk("R1 nibble ch23", d, 0);
      chk("R1 pin", pin, 0);
      chk("R1 stat", stat, 0);
      chk("R1 upd_en", upd_en, 0);
   endtask

   task automatic t_resume();
      int d;
      write_nib(3, 9);
      read_nib(3, d); chk("R5 no write before wait", d, 0);
      sf_pulse();
      chk("R5 enable after one strobe", upd_en, 0);
      repeat (4) step();
      chk("R5 enable mid superframe", upd_en, 0);
      sf_pulse();
      chk("R5 enable after second strobe", upd_en, 1);
   endtask

   task automatic t_write();
      int d;
      write_nib(5, 10);
      read_nib(5, d); chk("R7 ch5 readback", d, 10);
      write_nib(23, 6);
      read_nib(23, d); chk("R7 ch23 readback", d, 6);
      write_nib(30, 15);
      read_nib(30, d); chk("R7 out of range read", d, 0);
      read_nib(6, d);  chk("R7 no alias ch6", d, 0);
   endtask

   task automatic t_force();
      int d;
      force_freeze = 1'b1;
      #0.1;
      chk("R4 enable low same cycle", upd_en, 0);
      write_nib(5, 3);
      read_nib(5, d); chk("R4 nibble held", d, 10);
      chk("R2 pin on force", pin, 1);
      chk("R2 stat mirrors pin", stat, 1);
      force_freeze = 1'b0;
      step();
      chk("R2 pin clears", pin, 0);
      chk("R5 still waiting after release", upd_en, 0);
      go_run();
      chk("R5 running again", upd_en, 1);
   endtask

   task automatic t_auto();
      los = 1'b1; step(); chk("R2 pin on los", pin, 1); los = 1'b0; step();
      chk("R2 pin drop after los", pin, 0);
      lof = 1'b1; step(); chk("R2 pin on lof", pin, 1); lof = 1'b0; step();
      ext_mode = 1'b1; slip = 1'b1; step();
      chk("R2 pin on slip in ext mode", pin, 1);
      slip = 1'b0; ext_mode = 1'b0; step();
      chk("R2 enable dropped by auto", upd_en, 0);
      go_run();
   endtask

   task automatic t_slip_ignored();
      int d;
      ext_mode = 1'b0; slip = 1'b1;
      write_nib(7, 6);
      chk("R3 pin stays low", pin, 0);
      chk("R3 enable stays", upd_en, 1);
      read_nib(7, d); chk("R3 write went through", d, 6);
      slip = 1'b0;
   endtask

   task automatic t_restart();
      force_freeze = 1'b1; step(); force_freeze = 1'b0;
      step();
      sf_pulse();
      los = 1'b1; step(); step(); los = 1'b0;
      sf_pulse();
      chk("R6 one strobe after restart", upd_en, 0);
      step();
      sf_pulse();
      chk("R6 two strobes after restart", upd_en, 1);
   endtask

   task automatic t_strobe_frozen();
      force_freeze = 1'b1;
      step(); sf_pulse(); step(); sf_pulse();
      chk("R8 strobes during freeze", upd_en, 0);
      force_freeze = 1'b0;
      step();
      sf_pulse();
      chk("R8 first strobe after release", upd_en, 0);
      sf_pulse();
      chk("R8 second strobe after release", upd_en, 1);
   endtask

   task automatic t_reset_again();
      int d;
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      read_nib(5, d); chk("R1 store cleared", d, 0);
      chk("R1 waits after reset", upd_en, 0);
      go_run();
      chk("R5 run after reset wait", upd_en, 1);
   endtask

   initial begin
      t_reset();
      t_resume();
      t_write();
      t_force();
      t_auto();
      t_slip_ignored();
      t_restart();
      t_strobe_frozen();
      t_reset_again();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule